// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM that has 19 address lines, 8 data lines, and active-low select, write-strobe and output-gate controls. The host gives it one transfer at a time over a valid/ready handshake: an address, a direction flag and a write byte. The controller then drives the RAM pins so that every analogue timing minimum of the memory is met. For reads, it returns the fetched byte with a one-cycle strobe.

All pin timing is set by a clock-period parameter. Each nanosecond minimum is turned into a whole number of cycles by rounding up, and every phase lasts at least one cycle. Pin outputs come straight from flops, so they change only on clock edges. The data bus is modelled as an output byte, an output-enable and an input byte. No pad buffer is instantiated.

After reset the controller keeps the RAM deselected for a programmable recovery time. This covers the wait the memory needs after its supply returns. When a transfer's direction differs from the previous one, the controller inserts idle cycles so that neither side drives the bus while the other may still be driving it.

Top module: `sram_async_ctl`

## Requirements
- R1: Pin encoding: select high means no access. A read is select low, write strobe high and output gate low. A write is select low and write strobe low. The controller keeps the output gate high throughout a write and never pulls the write strobe low while select is high.
- R2: During a read, select and output gate stay low with a constant address for RD = max(ceil(55/T), ceil(25/T)) clock cycles (T = clock period in ns, so 7 cycles at 8 ns). The data pins are sampled on the clock edge that ends this phase.
- R3: The read byte appears on `rd_data` with `rd_valid` high for exactly one cycle. It equals the last byte written to that address, or the memory's existing content if nothing was written there. `rd_valid` is first seen RD+1 cycles after the accepting edge, plus the idle gap of R7 when that gap applies.
- R4: Write strobe and select are both low together for at least 40 ns. Select has been low, and the address constant, for at least 50 ns when the write strobe rises.
- R5: During a write, the controller drives the data byte from the first cycle of the transfer. The byte is constant for at least 25 ns before the write strobe rises, and it is still driven unchanged in the cycle after the strobe rises (positive hold).
- R6: The controller never enables its data drivers while the RAM may be driving the bus. This covers the whole read phase and 20 ns after select or output gate rises.
- R7: When a transfer's direction differs from that of the previous completed transfer, ceil(20/T) idle cycles (3 at 8 ns) with select high are inserted before the new transfer's pins are driven. The write strobe therefore first falls 2 cycles after the accepting edge, plus that gap when it applies.
- R8: After reset, select stays high and `req_ready` stays low for at least ceil(PWRUP_NS/T) cycles.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the transfer has finished, and it is only high while all RAM controls are inactive.
- R10: During reset, select, write strobe and output gate are high, the data drivers are off, and `req_ready` and `rd_valid` are low.
- R11: The address pins do not change while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read byte |
| sram_addr | output | 19 | RAM address pins |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output gate, active low |
| sram_dq_out | output | 8 | Byte driven onto the RAM data pins |
| sram_dq_oe | output | 1 | Enable for the data pin drivers |
| sram_dq_in | input | 8 | Byte read from the RAM data pins |

## Verification
The hardest case to reach from the ports is a read that ends and is followed at once by a write. Only in that case can the controller's drivers turn on while the memory is still releasing the bus. The bench issues transfers with random direction and zero to two idle cycles between them, so many read-then-write pairs land with no host gap. A pin-level memory model tracks the 20 ns release window and the access window, and it returns corrupted data when sampled too early. As a result, shortened phases show up both as timing violations and as wrong read bytes. The recovery wait is shortened by a parameter so that the first access after reset also falls inside the run.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_t;

  // ns -> whole cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int              CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int RD_CYC  = 7,
  parameter int WP_CYC  = 6,
  parameter int TA_CYC  = 3,
  parameter int PWR_CYC = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_we,
  output seq_state_t state_q,
  output seq_state_t state_d,
  output logic       accept,
  output logic       capture
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);
  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_CYC - 1);

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_zero;

  logic op_we_q, op_we_d;
  logic last_wr_q, last_wr_d;
  logic have_last_q, have_last_d;

  sram_ctl_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWR_LD)
  ) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    unique case (state_q)
      ST_PWRUP: begin
        if (t_zero) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          t_load = 1'b1;
          if (have_last_q && (last_wr_q != req_we)) begin
            state_d = ST_TURN;
            t_val   = TA_LD;
          end else if (req_we) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_RD;
            t_val   = RD_LD;
          end
        end
      end
      ST_TURN: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (op_we_q) begin
            state_d = ST_WSET;
          end else begin
            state_d = ST_RD;
            t_val   = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (t_zero) state_d = ST_IDLE;
      end
      ST_WSET: begin
        state_d = ST_WPULSE;
        t_load  = 1'b1;
        t_val   = WP_LD;
      end
      ST_WPULSE: begin
        if (t_zero) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign capture = (state_q == ST_RD) && t_zero;

  always_comb begin
    op_we_d     = op_we_q;
    last_wr_d   = last_wr_q;
    have_last_d = have_last_q;
    if (accept) op_we_d = req_we;
    if (capture) begin
      last_wr_d   = 1'b0;
      have_last_d = 1'b1;
    end else if (state_q == ST_WHOLD) begin
      last_wr_d   = 1'b1;
      have_last_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWRUP;
      op_we_q     <= 1'b0;
      last_wr_q   <= 1'b0;
      have_last_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      op_we_q     <= op_we_d;
      last_wr_q   <= last_wr_d;
      have_last_q <= have_last_d;
    end
  end

endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_d,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_n_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              doe_q,
  output logic              rdv_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic              cs_n_d, we_n_d, oe_n_d, doe_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] rdata_d;

  // pin decode of the coming state; registered below
  always_comb begin
    cs_n_d = !((state_d == ST_RD) || (state_d == ST_WSET) ||
               (state_d == ST_WPULSE) || (state_d == ST_WHOLD));
    oe_n_d = (state_d != ST_RD);
    we_n_d = (state_d != ST_WPULSE);
    doe_d  = (state_d == ST_WSET) || (state_d == ST_WPULSE) ||
             (state_d == ST_WHOLD);
    addr_d  = accept  ? req_addr  : addr_q;
    dout_d  = accept  ? req_wdata : dout_q;
    rdata_d = capture ? dq_in     : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      doe_q   <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
      rdv_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      doe_q   <= doe_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      rdv_q   <= capture;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_ACC_NS      = 55,
  parameter int T_OEACC_NS    = 25,
  parameter int T_WPULSE_NS   = 40,
  parameter int T_SELEND_NS   = 50,
  parameter int T_ADREND_NS   = 50,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_RELEASE_NS  = 20,
  parameter int PWRUP_NS      = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RD_CYC = imax(imax(ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS)),
                               ns_to_cyc(T_OEACC_NS, CLK_PERIOD_NS));
  // one setup cycle and one hold cycle surround the strobe
  localparam int WP_CYC = imax(imax(imax(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_SELEND_NS, CLK_PERIOD_NS) - 1),
                                    imax(ns_to_cyc(T_ADREND_NS, CLK_PERIOD_NS) - 1,
                                         ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS) - 1)),
                               imax(ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS) - 2, 1));
  localparam int TA_CYC  = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int PWR_CYC = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(TA_CYC, PWR_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic       rst_n_s;
  seq_state_t st_q, st_d;
  logic       accept, capture;

  sram_ctl_rst_sync i_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sram_ctl_seq #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .TA_CYC  (TA_CYC),
    .PWR_CYC (PWR_CYC)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_we    (req_we),
    .state_q   (st_q),
    .state_d   (st_d),
    .accept    (accept),
    .capture   (capture)
  );

  sram_ctl_io #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_io (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .state_d   (st_d),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .addr_q    (sram_addr),
    .cs_n_q    (sram_cs_n),
    .we_n_q    (sram_we_n),
    .oe_n_q    (sram_oe_n),
    .dout_q    (sram_dq_out),
    .doe_q     (sram_dq_oe),
    .rdv_q     (rd_valid),
    .rdata_q   (rd_data)
  );

  assign req_ready = (st_q == ST_IDLE);

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int PWRUP_NS      = 5000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  localparam int PWR_CYC = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);
  localparam int SW      = $clog2(PWR_CYC + 1);
  localparam logic [SW-1:0] PWR_MAX = SW'(PWR_CYC);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= '0;
    else if (since_q != PWR_MAX) since_q <= since_q + 1'b1;
  end

  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n); // R1
  AST_NO_GATE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R1
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe); // R6
  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> ($past(!sram_cs_n) && $past(sram_dq_oe))); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R5
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R11
  AST_PWRUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_cs_n) |-> (since_q >= PWR_MAX)); // R8

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .PWRUP_NS      (PWRUP_NS)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid),
  .sram_addr   (sram_addr),
  .sram_cs_n   (sram_cs_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_async_ctl.sv
`timescale 1ns/1ps
module test_sram_async_ctl;

  localparam int PER    = 8;
  localparam int PWR_NS = 400;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_C  = (cdiv(55) > cdiv(25)) ? cdiv(55) : cdiv(25);
  localparam int TA_C  = cdiv(20);
  localparam int PWR_C = cdiv(PWR_NS);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic        req_ready;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [18:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in;

  always #4 clk = ~clk;

  sram_async_ctl #(
    .CLK_PERIOD_NS (PER),
    .PWRUP_NS      (PWR_NS)
  ) i_sram_async_ctl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .sram_addr (sram_addr), .sram_cs_n (sram_cs_n), .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n), .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe),
    .sram_dq_in (sram_dq_in)
  );

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input logic [18:0] a);
    return a[7:0] ^ a[18:11] ^ 8'h3C;
  endfunction

  // memory model (pin side) and expected contents (host side)
  logic [7:0] mem     [int];
  logic [7:0] exp_mem [int];

  function automatic logic [7:0] mem_rd(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_byte(a);
  endfunction
  function automatic logic [7:0] exp_rd(input logic [18:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_byte(a);
  endfunction

  // ---------------- pin monitor and memory model ----------------
  bit          mon_en = 0;
  bit          prev_cs, prev_we, prev_doe, prev_drv, first_cs, moved, r1_bad;
  logic [18:0] prev_addr;
  logic [7:0]  prev_dout;
  int          wp_cnt, cs_cnt, a_stab, d_stab, rd_cnt, rel_left, pw_cnt;

  always @(negedge clk) begin
    bit drv;
    if (!mon_en) begin
      prev_cs = 1; prev_we = 1; prev_doe = 0; prev_drv = 0;
      first_cs = 0; moved = 0; r1_bad = 0;
      prev_addr = '0; prev_dout = '0;
      wp_cnt = 0; cs_cnt = 0; a_stab = 0; d_stab = 0; rd_cnt = 0;
      rel_left = 0; pw_cnt = 0;
      sram_dq_in = 8'h00;
    end else begin
      drv = !sram_cs_n && !sram_oe_n && sram_we_n;
      if (!sram_we_n && (sram_cs_n || !sram_oe_n)) r1_bad = 1;
      if (!sram_cs_n && !prev_cs && sram_addr != prev_addr) moved = 1;
      // R6: drivers must not turn on inside the memory's drive window
      if (sram_dq_oe && !prev_doe)
        chk(!drv && rel_left == 0, "R6", "drive while memory active",
            rel_left, 0);
      if (drv) rel_left = TA_C - 1;
      else if (rel_left > 0) rel_left--;
      // end of write
      if (!prev_we && !prev_cs && (sram_we_n || sram_cs_n)) begin
        chk(wp_cnt * PER >= 40, "R4", "strobe ns", wp_cnt * PER, 40);
        chk(cs_cnt * PER >= 50, "R4", "select-to-end ns", cs_cnt * PER, 50);
        chk(a_stab * PER >= 50, "R4", "address-to-end ns", a_stab * PER, 50);
        chk(d_stab * PER >= 25, "R5", "data setup ns", d_stab * PER, 25);
        chk(sram_dq_oe && sram_dq_out == prev_dout, "R5", "data hold",
            sram_dq_out, prev_dout);
        chk(!r1_bad, "R1", "control encoding", r1_bad, 0);
        mem[int'(prev_addr)] = prev_dout;
      end
      // end of read
      if (prev_drv && !drv)
        chk(rd_cnt * PER >= 55, "R2", "read window ns", rd_cnt * PER, 55);
      // select released
      if (!prev_cs && sram_cs_n) begin
        chk(!moved, "R11", "address moved under select", moved, 0);
        moved = 0;
      end
      if (!first_cs) begin
        if (sram_cs_n) pw_cnt++;
        else begin
          first_cs = 1;
          chk(pw_cnt >= PWR_C, "R8", "cycles before first select", pw_cnt, PWR_C);
        end
      end
      wp_cnt = (!sram_cs_n && !sram_we_n) ? wp_cnt + 1 : 0;
      cs_cnt = !sram_cs_n ? cs_cnt + 1 : 0;
      a_stab = (sram_addr == prev_addr) ? a_stab + 1 : 1;
      d_stab = (sram_dq_oe && prev_doe && sram_dq_out == prev_dout) ? d_stab + 1
             : (sram_dq_oe ? 1 : 0);
      rd_cnt = drv ? ((prev_drv && sram_addr == prev_addr) ? rd_cnt + 1 : 1) : 0;
      sram_dq_in = (drv && rd_cnt * PER >= 55) ? mem_rd(sram_addr)
                                               : ~mem_rd(sram_addr);
      prev_cs = sram_cs_n; prev_we = sram_we_n; prev_doe = sram_dq_oe;
      prev_drv = drv; prev_addr = sram_addr; prev_dout = sram_dq_out;
    end
  end

  // ---------------- host-side tasks (called at a falling edge) ----------------
  bit have_last = 0;
  bit last_we   = 0;

  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d,
                       output bit turn);
    turn = have_last && (last_we != we);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    have_last = 1; last_we = we;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    bit turn;
    int lat;
    issue(1'b1, a, d, turn);
    exp_mem[int'(a)] = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 0;
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
      end
    end while (sram_we_n && lat < 100);
    chk(lat == 2 + (turn ? TA_C : 0), "R7", "strobe latency", lat,
        2 + (turn ? TA_C : 0));
  endtask

  task automatic do_read(input logic [18:0] a);
    bit turn;
    int lat;
    issue(1'b0, a, 8'h00, turn);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 0;
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
      end
    end while (!rd_valid && lat < 100);
    chk(lat == RD_C + 1 + (turn ? TA_C : 0), "R3", "read latency", lat,
        RD_C + 1 + (turn ? TA_C : 0));
    chk(rd_data == exp_rd(a), "R3", "read data", rd_data, exp_rd(a));
    @(negedge clk);
    chk(!rd_valid, "R3", "strobe width", rd_valid, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [18:0] pool [8];
    void'($urandom(32'd715));
    for (int i = 0; i < 8; i++) pool[i] = 19'(i * 32'h0F0F1 + 7);
    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R10", "controls idle in reset",
        {sram_cs_n, sram_we_n, sram_oe_n}, 7);
    chk(!sram_dq_oe && !req_ready && !rd_valid, "R10", "outputs quiet in reset",
        {sram_dq_oe, req_ready, rd_valid}, 0);
    rst_n = 1; mon_en = 1;
    repeat (PWR_C - 1) @(negedge clk);
    chk(!req_ready && sram_cs_n, "R8", "still waiting", req_ready, 0);
    // directed corners
    do_read(19'h12345);                 // never written: existing content
    do_write(19'h00000, 8'hA5);
    do_read(19'h00000);                 // write -> read with idle gap
    do_write(19'h7FFFF, 8'hFF);         // read -> write with idle gap
    do_write(19'h7FFFF, 8'h00);         // same direction, no gap
    do_read(19'h7FFFF);
    do_read(19'h00000);                 // read -> read back to back
    do_write(19'h2AAAA, 8'h5A);
    do_read(19'h2AAAA);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      a = ($urandom_range(0, 3) == 0) ? 19'($urandom) : pool[$urandom_range(0, 7)];
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else                           do_read(a);
    end
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule